// File: doc/BRIEF.md
# Discover-then-Lock Protected Window Control Register

This block is a single byte-wide control register that lets boot firmware first probe whether a protected memory window at a fixed base address is available, and then switch that window on for good. Firmware writes the register through a byte port. Every bit has a write-enable mask that the block keeps internally and reports on an output. The block has two enable outputs. One tells the address decoder to turn normal-mode accesses to the window into a blackhole. The other opens the same range for system-management-mode accesses. The window's address decode sits outside this block.

Discovery works by writing a magic probe value. A correct probe changes what the register reads back, to a fixed capability answer, and narrows the write mask so that only the lock bit can still be written. A write made before the probe is thrown away. Once the lock bit has been written after a probe, it cannot be cleared until reset.

A compile-time parameter states whether the feature exists in a given build. When it does not exist, the register reads as zero, its mask reads as zero, and neither enable can ever assert.

Top module: `qlk_feature_reg`

## Requirements
- R1: With `PRESENT` = 0, `rd_data` and `wr_mask` stay 0x00, and `guard_en` and `smm_win_en` stay low, whatever is written.
- R2: One clock edge after `rst_n` is sampled low, `rd_data` is 0x00, `wr_mask` is 0xFF, and both enables are low.
- R3: A write whose merged value is the probe code 0xFF, made while `wr_mask` is 0xFF, makes `rd_data` read 0x01 (capability answer) and `wr_mask` read 0x02 (bit 1 only) on the next edge. Both enables stay low.
- R4: While `wr_mask` is still 0xFF, a write of any value other than 0xFF leaves `rd_data` at 0x00 and both enables low, even when bit 1 of the data is set.
- R5: After a probe, a write with bit 1 (the lock bit) set makes `rd_data` read 0x02, makes `wr_mask` read 0x00, and drives `guard_en` and `smm_win_en` high on the next edge.
- R6: After a probe, a write with bit 1 clear leaves both enables low. `rd_data` keeps 0x01, because bit 0 is not writable after the probe.
- R7: Once locked, later writes of any value change neither `rd_data`, `wr_mask` nor the enables until reset.
- R8: Outputs change only on the clock edge that follows an accepted write. With `wr_en` low, all outputs hold their values.
- R9: Reset clears a lock. After reset the probe and lock sequence can be run again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, one cycle per write |
| wr_data | input | 8 | Byte written to the register |
| rd_data | output | 8 | Current register value |
| wr_mask | output | 8 | Current per-bit write mask |
| guard_en | output | 1 | Enable for the normal-mode blackhole over the window |
| smm_win_en | output | 1 | Enable for the system-management-mode window |

## Verification
The bench builds two copies of the block side by side and drives both with the same writes. One copy uses `PRESENT` = 1 and the default byte width, probe code, answer and lock position. The other uses `PRESENT` = 0. The present copy goes through every stage: a fresh register with writes being discarded, a probe, a write that leaves it unlocked, a lock, writes after the lock, and a second reset followed by probing and locking again. The absent copy sees the same writes, including the probe and lock values, so every one of them also shows that the feature stays inert when it is not present.

// File: rtl/qlk_pkg.sv
// Package: qlk_pkg
// Holds the default codes shared by the feature register, its submodules
// and its checker. Assumes an 8-bit register unless a parent overrides.
package qlk_pkg;
    localparam int          QLK_W        = 8;
    localparam logic [7:0]  QLK_PROBE    = 8'hFF;
    localparam logic [7:0]  QLK_ANSWER   = 8'h01;
    localparam int          QLK_LOCK_IDX = 1;
endpackage

// File: rtl/qlk_merge.sv
// Module: qlk_merge
// Combines the incoming byte with the stored value bit by bit. Bits whose
// mask is set take the new data, and the others keep the stored value.
// Assumes the caller decides what to do with the merged result.
module qlk_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur_val,
    input  logic [W-1:0] cur_mask,
    input  logic [W-1:0] new_data,
    output logic [W-1:0] merged
);
    // one selector per bit: a masked bit follows the data, an unmasked bit holds
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign merged[b] = cur_mask[b] ? new_data[b] : cur_val[b];
    end
endmodule

// File: rtl/qlk_ctrl.sv
// Module: qlk_ctrl
// Holds the register value, the write mask and the lock flag. It treats the
// merged probe code as a discovery request, discards writes made before
// discovery, and makes the lock sticky. Assumes a synchronous active-low
// reset and a one-cycle wr_en strobe.
module qlk_ctrl #(
    parameter int          W          = 8,
    parameter logic [W-1:0] PROBE_CODE = '1,
    parameter logic [W-1:0] ANSWER     = W'(1),
    parameter int          LOCK_IDX   = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] merged,
    output logic [W-1:0] val_q,
    output logic [W-1:0] mask_q,
    output logic         lock_q
);
    localparam logic [W-1:0] LOCK_MASK = W'(1) << LOCK_IDX;
    localparam logic [W-1:0] FULL_MASK = '1;

    logic [W-1:0] val_d;
    logic [W-1:0] mask_d;
    logic         lock_d;
    logic [W-1:0] kept;
    logic         fresh;

    // a register whose mask is still fully open has not been probed yet
    assign fresh = (mask_q == FULL_MASK);

    // before discovery a non-probe write is thrown away
    assign kept = fresh ? '0 : merged;

    // next-state decision for one write
    always_comb begin
        val_d  = val_q;
        mask_d = mask_q;
        lock_d = lock_q;
        if (wr_en) begin
            if (merged == PROBE_CODE) begin
                val_d  = ANSWER;
                mask_d = LOCK_MASK;
                lock_d = 1'b0;
            end else if (kept[LOCK_IDX]) begin
                val_d  = LOCK_MASK;
                mask_d = mask_q & ~LOCK_MASK;
                lock_d = 1'b1;
            end else begin
                val_d  = kept;
                lock_d = 1'b0;
            end
        end
    end

    // state flops with synchronous reset to the fresh, unprobed state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q  <= '0;
            mask_q <= FULL_MASK;
            lock_q <= 1'b0;
        end else begin
            val_q  <= val_d;
            mask_q <= mask_d;
            lock_q <= lock_d;
        end
    end
endmodule

// File: rtl/qlk_feature_reg.sv
// Module: qlk_feature_reg
// Top of the probe-then-lock window control register. The PRESENT parameter
// selects whether the feature exists. When it is absent, writes are gated
// off and every output is tied inactive. Assumes the window decode is done
// elsewhere using guard_en and smm_win_en.
module qlk_feature_reg #(
    parameter bit          PRESENT    = 1'b1,
    parameter int          W          = qlk_pkg::QLK_W,
    parameter logic [W-1:0] PROBE_CODE = W'(qlk_pkg::QLK_PROBE),
    parameter logic [W-1:0] ANSWER     = W'(qlk_pkg::QLK_ANSWER),
    parameter int          LOCK_IDX   = qlk_pkg::QLK_LOCK_IDX
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] wr_mask,
    output logic         guard_en,
    output logic         smm_win_en
);
    logic [W-1:0] val_q;
    logic [W-1:0] mask_q;
    logic         lock_q;
    logic [W-1:0] merged;
    logic         wr_gated;

    qlk_merge #(.W(W)) u_merge (
        .cur_val  (val_q),
        .cur_mask (mask_q),
        .new_data (wr_data),
        .merged   (merged)
    );

    qlk_ctrl #(
        .W          (W),
        .PROBE_CODE (PROBE_CODE),
        .ANSWER     (ANSWER),
        .LOCK_IDX   (LOCK_IDX)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_gated),
        .merged (merged),
        .val_q  (val_q),
        .mask_q (mask_q),
        .lock_q (lock_q)
    );

    // the build variant picks either live outputs or inert ones
    if (PRESENT) begin : g_live
        assign wr_gated   = wr_en;
        assign rd_data    = val_q;
        assign wr_mask    = mask_q;
        assign guard_en   = lock_q;
        assign smm_win_en = lock_q;
    end else begin : g_inert
        assign wr_gated   = 1'b0;
        assign rd_data    = (val_q & '0);
        assign wr_mask    = (mask_q & '0);
        assign guard_en   = lock_q & 1'b0;
        assign smm_win_en = lock_q & 1'b0;
    end
endmodule

// File: rtl/qlk_feature_reg_chk.sv
// Module: qlk_feature_reg_chk
// Property checker for qlk_feature_reg, attached through bind. It only
// observes the top-level ports. Assumes the default lock position and codes
// are passed down from the bound instance.
module qlk_feature_reg_chk #(
    parameter bit          PRESENT    = 1'b1,
    parameter int          W          = 8,
    parameter logic [W-1:0] PROBE_CODE = '1,
    parameter logic [W-1:0] ANSWER     = W'(1),
    parameter int          LOCK_IDX   = 1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] wr_mask,
    input logic         guard_en,
    input logic         smm_win_en
);
    localparam logic [W-1:0] LOCK_MASK = W'(1) << LOCK_IDX;

    AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !PRESENT |-> (rd_data == '0 && wr_mask == '0 && !guard_en && !smm_win_en)); // R1

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESENT && $rose(rst_n)) |-> (rd_data == '0 && wr_mask == '1 && !guard_en)); // R2

    AST_PROBE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESENT && wr_en && wr_mask == '1 && wr_data == PROBE_CODE)
        |=> (rd_data == ANSWER && wr_mask == LOCK_MASK && !guard_en)); // R3

    AST_EARLY_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESENT && wr_en && wr_mask == '1 && wr_data != PROBE_CODE)
        |=> (rd_data == '0 && !guard_en && !smm_win_en)); // R4

    AST_LOCK_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        guard_en |-> (rd_data == LOCK_MASK && wr_mask == '0)); // R5

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_en && smm_win_en) |=> (guard_en && smm_win_en)); // R7

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rd_data) && $stable(wr_mask) && $stable(guard_en))); // R8
endmodule

bind qlk_feature_reg qlk_feature_reg_chk #(
    .PRESENT    (PRESENT),
    .W          (W),
    .PROBE_CODE (PROBE_CODE),
    .ANSWER     (ANSWER),
    .LOCK_IDX   (LOCK_IDX)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .wr_mask    (wr_mask),
    .guard_en   (guard_en),
    .smm_win_en (smm_win_en)
);

// File: tb/qlk_feature_reg_bench.sv
// Scoreboard bench: driver tasks update a requirement-level model and queue
// expected outputs; a monitor pops and compares them one edge later.
module qlk_feature_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;

    logic [7:0] rd_a, mask_a, rd_b, mask_b;
    logic       grd_a, smm_a, grd_b, smm_b;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    typedef struct {
        int         due;
        logic [7:0] rd;
        logic [7:0] mask;
        logic       en;
        string      tag;
    } exp_t;

    exp_t sb[$];

    // model state taken from the requirements
    logic [7:0] m_val;
    logic [7:0] m_mask;
    logic       m_lock;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    qlk_feature_reg #(.PRESENT(1'b1)) u_qlk_feature_reg (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .rd_data (rd_a), .wr_mask (mask_a), .guard_en (grd_a), .smm_win_en (smm_a)
    );

    qlk_feature_reg #(.PRESENT(1'b0)) u_qlk_feature_reg_off (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
        .rd_data (rd_b), .wr_mask (mask_b), .guard_en (grd_b), .smm_win_en (smm_b)
    );

    task automatic push_exp(input string tag);
        exp_t e;
        e.due  = cyc + 1;
        e.rd   = m_val;
        e.mask = m_mask;
        e.en   = m_lock;
        e.tag  = tag;
        sb.push_back(e);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        m_val = 8'h00; m_mask = 8'hFF; m_lock = 1'b0;
        push_exp(tag);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] d, input string tag);
        logic [7:0] mg;
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        mg = (m_val & ~m_mask) | (d & m_mask);
        if (m_mask == 8'hFF && mg == 8'hFF) begin
            m_val = 8'h01; m_mask = 8'h02; m_lock = 1'b0;
        end else begin
            if (m_mask == 8'hFF) mg = 8'h00;
            if (mg[1]) begin
                m_val = 8'h02; m_mask = m_mask & 8'hFD; m_lock = 1'b1;
            end else begin
                m_val = mg; m_lock = 1'b0;
            end
        end
        push_exp(tag);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_idle(input string tag);
        @(negedge clk);
        push_exp(tag);
    endtask

    // monitor: compare both instances once an expected item is due
    always @(negedge clk) begin
        if (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (rd_a !== e.rd || mask_a !== e.mask || grd_a !== e.en || smm_a !== e.en) begin
                n_bad++;
                $display("FAIL %s: rd=%h mask=%h en=%b/%b expected rd=%h mask=%h en=%b",
                         e.tag, rd_a, mask_a, grd_a, smm_a, e.rd, e.mask, e.en);
            end
            n_vec++;
            if (rd_b !== 8'h00 || mask_b !== 8'h00 || grd_b !== 1'b0 || smm_b !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 (%s): absent rd=%h mask=%h en=%b/%b expected rd=00 mask=00 en=0",
                         e.tag, rd_b, mask_b, grd_b, smm_b);
            end
        end
    end

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        do_reset("R2 reset state");
        do_idle("R8 idle hold after reset");
        do_write(8'h02, "R4 lock before probe discarded");
        do_write(8'h55, "R4 other value before probe discarded");
        do_write(8'hFF, "R3 probe answer and narrowed mask");
        do_idle("R8 idle hold after probe");
        do_write(8'h00, "R6 lock clear keeps answer bit");
        do_write(8'hFD, "R6 all but lock bit stays unlocked");
        do_write(8'h02, "R5 lock engages");
        do_write(8'h00, "R7 clear attempt after lock");
        do_write(8'hFF, "R7 probe attempt after lock");
        do_idle("R8 idle hold while locked");
        do_reset("R9 reset clears lock");
        do_write(8'hFF, "R3 probe again after reset");
        do_write(8'hFF, "R5 all-ones write locks after probe");
        do_write(8'hFD, "R7 write after second lock");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule